// File: doc/BRIEF.md
# Shift-and-Saturate Clamp Unit

This unit clamps a 32-bit operand to a programmable bit width within the same cycle. It supports four operations. Two work on the whole word: a signed clamp and an unsigned clamp, each preceded by a logical-left or arithmetic-right pre-shift. The other two work on the two halfwords independently, again one signed and one unsigned. A combinational path produces the result word, a write-enable and an overflow pulse. A one-bit register keeps a sticky saturation flag that gathers every clamping event until it is cleared.

The condition result arrives already evaluated on `cond_pass_i`, and the destination and source register indices arrive with it. If either index names the program counter (index 15), the unit signals an unpredictable operation and does not execute.

The sticky flag is a two-state machine. `FLAG_CLEAR` moves to `FLAG_SET` through the transition *saturate*, taken when `ovf_o` is high and no clear is requested. `FLAG_SET` returns to `FLAG_CLEAR` through the transition *clear*, taken when `flag_clr_i` is high. In every other cycle both states hold.

Top module: `clamp_unit`

## Requirements
- R1: With op code 0 (signed word), the pre-shifted operand is clamped as a signed value to n = sat_field + 1 bits (1 to 32), giving the range [-2^(n-1), 2^(n-1)-1]. The result is sign-extended to 32 bits.
- R2: With op code 1 (unsigned word), the pre-shifted operand is taken as a signed value and clamped to [0, 2^n - 1], where n is sat_field itself (0 to 31). A width of 0 always yields 0.
- R3: In the word forms, shift_arith_i = 0 shifts the operand left logically by shamt_i before clamping. shift_arith_i = 1 shifts it right arithmetically by shamt_i, and an amount of 0 then means a shift by 32, which gives all sign bits.
- R4: With op codes 2 (signed halfword) and 3 (unsigned halfword), each 16-bit half is clamped on its own, using the width rule of the matching word form applied to sat_field bits 3:0. The clamped low half goes to result bits 15:0 and the clamped high half to bits 31:16.
- R5: With op code 3, each half is sign-extended before clamping, so a half with bit 15 set becomes 0 and counts as a clamping event.
- R6: ovf_o is high in the same cycle as an executed operation in which any clamp changed a value, including a change to either half. Otherwise ovf_o is low.
- R7: sticky_o becomes 1 in the cycle after ovf_o is high, and it stays 1 until it is cleared.
- R8: sticky_o is 0 after reset. flag_clr_i clears it in the following cycle and wins over a simultaneous overflow.
- R9: When cond_pass_i is low, wr_en_o and ovf_o stay low and sticky_o keeps its value.
- R10: When dst_idx_i or src_idx_i equals 15, unpred_o is high and wr_en_o and ovf_o are low, whatever the value of cond_pass_i. sticky_o keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| op_i | input | 2 | Operation: 0 signed word, 1 unsigned word, 2 signed halves, 3 unsigned halves |
| operand_i | input | 32 | Source value |
| sat_field_i | input | 5 | Width field (bits 3:0 used by the halfword forms) |
| shamt_i | input | 5 | Pre-shift amount for the word forms |
| shift_arith_i | input | 1 | 0 = logical left, 1 = arithmetic right |
| cond_pass_i | input | 1 | Condition already evaluated as true |
| dst_idx_i | input | 4 | Destination register index |
| src_idx_i | input | 4 | Source register index |
| flag_clr_i | input | 1 | Synchronous clear of the sticky flag |
| result_o | output | 32 | Clamped result |
| wr_en_o | output | 1 | Result is to be written |
| ovf_o | output | 1 | Clamping happened in this operation |
| sticky_o | output | 1 | Sticky saturation flag |
| unpred_o | output | 1 | Program-counter index seen; operation not executed |

## Verification
The assertions check the flag machine on every cycle: it is set after an overflow, cleared by a request, and otherwise holds. They also check that an unpredictable or failed-condition operation never writes or raises overflow, and that an unsigned half with its top bit set always clamps to zero. Only the bench's scenarios can show the clamp values themselves. These are the range edges for the smallest and largest widths, the width-zero case and both shift directions, including the shift by 32. The scenarios also confirm the packing order of the halves.

// File: rtl/clamp_pkg.sv
package clamp_pkg;
    localparam int HALF_W = 16;
    localparam int NHALF  = 2;

    typedef enum logic [1:0] {
        OP_SAT_S_WORD = 2'd0,
        OP_SAT_U_WORD = 2'd1,
        OP_SAT_S_HALF = 2'd2,
        OP_SAT_U_HALF = 2'd3
    } clamp_op_e;

    typedef enum logic {
        FLAG_CLEAR = 1'b0,
        FLAG_SET   = 1'b1
    } flag_state_e;
endpackage

// File: rtl/clamp_preshift.sv
module clamp_preshift #(
    parameter int W  = 32,
    parameter int SW = $clog2(W)
) (
    input  logic [W-1:0]  val_i,
    input  logic [SW-1:0] amt_i,
    input  logic          arith_i,
    output logic [W-1:0]  val_o
);
    always_comb begin
        if (!arith_i) begin
            val_o = val_i << amt_i;
        end else if (amt_i == '0) begin
            // encoded zero stands for a full-width shift
            val_o = {W{val_i[W-1]}};
        end else begin
            val_o = $signed(val_i) >>> amt_i;
        end
    end
endmodule

// File: rtl/clamp_sat.sv
module clamp_sat #(
    parameter int IN_W = 32,
    parameter int NW   = $clog2(IN_W + 1)
) (
    input  logic [IN_W-1:0] val_i,
    input  logic [NW-1:0]   width_i,
    input  logic            signed_i,
    output logic [IN_W-1:0] val_o,
    output logic            ovf_o
);
    localparam int EW = IN_W + 2;
    localparam logic [NW-1:0] ONE_W = 1;

    logic signed [EW-1:0] ext, lim_hi, lim_lo, unit;

    always_comb begin
        unit = 1;
        ext  = {{2{val_i[IN_W-1]}}, val_i};
        if (signed_i) begin
            lim_hi = (unit <<< (width_i - ONE_W)) - unit;
            lim_lo = -(unit <<< (width_i - ONE_W));
        end else begin
            lim_hi = (unit <<< width_i) - unit;
            lim_lo = '0;
        end
        if (ext > lim_hi) begin
            val_o = lim_hi[IN_W-1:0];
            ovf_o = 1'b1;
        end else if (ext < lim_lo) begin
            val_o = lim_lo[IN_W-1:0];
            ovf_o = 1'b1;
        end else begin
            val_o = val_i;
            ovf_o = 1'b0;
        end
    end
endmodule

// File: rtl/clamp_unit.sv
module clamp_unit
    import clamp_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int IDX_W  = 4
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [1:0]                op_i,
    input  logic [DATA_W-1:0]         operand_i,
    input  logic [$clog2(DATA_W)-1:0] sat_field_i,
    input  logic [$clog2(DATA_W)-1:0] shamt_i,
    input  logic                      shift_arith_i,
    input  logic                      cond_pass_i,
    input  logic [IDX_W-1:0]          dst_idx_i,
    input  logic [IDX_W-1:0]          src_idx_i,
    input  logic                      flag_clr_i,
    output logic [DATA_W-1:0]         result_o,
    output logic                      wr_en_o,
    output logic                      ovf_o,
    output logic                      sticky_o,
    output logic                      unpred_o
);
    localparam int FW  = $clog2(DATA_W);
    localparam int WNW = $clog2(DATA_W + 1);
    localparam int HFW = $clog2(HALF_W);
    localparam int HNW = $clog2(HALF_W + 1);
    localparam logic [IDX_W-1:0] PC_IDX = '1;

    clamp_op_e   op;
    flag_state_e state_q, state_d;

    logic [DATA_W-1:0] shifted, word_res;
    logic [WNW-1:0]    word_w;
    logic              word_ovf, word_signed, half_signed, is_word, sat_hit;
    logic [HNW-1:0]    half_w;
    logic [NHALF-1:0][HALF_W-1:0] half_res;
    logic [NHALF-1:0]             half_ovf;

    assign op          = clamp_op_e'(op_i);
    assign word_signed = (op == OP_SAT_S_WORD);
    assign half_signed = (op == OP_SAT_S_HALF);
    assign is_word     = (op == OP_SAT_S_WORD) || (op == OP_SAT_U_WORD);
    assign word_w      = word_signed ? {1'b0, sat_field_i} + WNW'(1) : {1'b0, sat_field_i};
    assign half_w      = half_signed ? {1'b0, sat_field_i[HFW-1:0]} + HNW'(1)
                                     : {1'b0, sat_field_i[HFW-1:0]};

    clamp_preshift #(.W(DATA_W)) u_shift (
        .val_i   (operand_i),
        .amt_i   (shamt_i),
        .arith_i (shift_arith_i),
        .val_o   (shifted)
    );

    clamp_sat #(.IN_W(DATA_W)) u_word_sat (
        .val_i    (shifted),
        .width_i  (word_w),
        .signed_i (word_signed),
        .val_o    (word_res),
        .ovf_o    (word_ovf)
    );

    for (genvar g = 0; g < NHALF; g++) begin : g_half
        clamp_sat #(.IN_W(HALF_W)) u_half_sat (
            .val_i    (operand_i[g*HALF_W +: HALF_W]),
            .width_i  (half_w),
            .signed_i (half_signed),
            .val_o    (half_res[g]),
            .ovf_o    (half_ovf[g])
        );
    end

    always_comb begin
        unique case (op)
            OP_SAT_S_WORD, OP_SAT_U_WORD: result_o = word_res;
            OP_SAT_S_HALF, OP_SAT_U_HALF: result_o = half_res;
            default:                      result_o = '0;
        endcase
    end

    assign sat_hit  = is_word ? word_ovf : |half_ovf;
    assign unpred_o = (dst_idx_i == PC_IDX) || (src_idx_i == PC_IDX);
    assign wr_en_o  = cond_pass_i && !unpred_o;
    assign ovf_o    = wr_en_o && sat_hit;

    // sticky flag machine: state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= FLAG_CLEAR;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            FLAG_CLEAR: if (ovf_o && !flag_clr_i) state_d = FLAG_SET;
            FLAG_SET:   if (flag_clr_i)           state_d = FLAG_CLEAR;
            default:                              state_d = FLAG_CLEAR;
        endcase
    end

    // sticky flag machine: outputs
    always_comb begin
        sticky_o = (state_q == FLAG_SET);
    end

    a_r7_sticky_set: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_o && !flag_clr_i) |=> sticky_o);
    a_r8_sticky_clear: assert property (@(posedge clk) disable iff (!rst_n)
        flag_clr_i |=> !sticky_o);
    a_r9_sticky_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!ovf_o && !flag_clr_i) |=> $stable(sticky_o));
    a_r9_no_write_on_fail: assert property (@(posedge clk) disable iff (!rst_n)
        !cond_pass_i |-> (!wr_en_o && !ovf_o));
    a_r10_unpred_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        unpred_o |-> (!wr_en_o && !ovf_o));
    a_r5_neg_half_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == 2'd3 && operand_i[HALF_W-1]) |-> (result_o[HALF_W-1:0] == '0));
endmodule

// File: tb/test_clamp_unit.sv
module test_clamp_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  op_i = '0;
    logic [31:0] operand_i = '0;
    logic [4:0]  sat_field_i = '0;
    logic [4:0]  shamt_i = '0;
    logic        shift_arith_i = 1'b0;
    logic        cond_pass_i = 1'b0;
    logic [3:0]  dst_idx_i = '0;
    logic [3:0]  src_idx_i = '0;
    logic        flag_clr_i = 1'b0;
    logic [31:0] result_o;
    logic        wr_en_o, ovf_o, sticky_o, unpred_o;

    int errors = 0;
    int checks = 0;
    bit model_stk = 1'b0;
    bit finished = 1'b0;

    typedef struct {
        logic [31:0] res;
        bit          wr, ovf, unp, stk;
        string       tag;
    } exp_t;
    exp_t sb[$];

    always #5 clk = ~clk;

    clamp_unit i_clamp_unit (
        .clk, .rst_n, .op_i, .operand_i, .sat_field_i, .shamt_i, .shift_arith_i,
        .cond_pass_i, .dst_idx_i, .src_idx_i, .flag_clr_i,
        .result_o, .wr_en_o, .ovf_o, .sticky_o, .unpred_o
    );

    function automatic void sat_model(input longint x, input int n, input bit sgn,
                                      output longint r, output bit o);
        longint hi, lo;
        if (sgn) begin
            hi = (64'sd1 <<< (n - 1)) - 1;
            lo = -(64'sd1 <<< (n - 1));
        end else begin
            hi = (64'sd1 <<< n) - 1;
            lo = 0;
        end
        if (x > hi)      begin r = hi; o = 1'b1; end
        else if (x < lo) begin r = lo; o = 1'b1; end
        else             begin r = x;  o = 1'b0; end
    endfunction

    task automatic drive(input string tag, input logic [1:0] op, input logic [31:0] val,
                         input logic [4:0] fld, input logic [4:0] sh, input bit arith,
                         input bit cond, input logic [3:0] dst, input logic [3:0] src,
                         input bit clr);
        exp_t e;
        longint x, r, rl, rh;
        bit o, ol, oh;
        logic [31:0] s;
        @(posedge clk);
        #1;
        op_i = op; operand_i = val; sat_field_i = fld; shamt_i = sh;
        shift_arith_i = arith; cond_pass_i = cond; dst_idx_i = dst;
        src_idx_i = src; flag_clr_i = clr;
        if (op < 2) begin
            if (!arith) begin
                s = val << sh;
                x = longint'($signed(s));
            end else begin
                x = longint'($signed(val)) >>> ((sh == 0) ? 32 : int'(sh));
            end
            sat_model(x, (op == 0) ? int'(fld) + 1 : int'(fld), op == 0, r, o);
            e.res = r[31:0];
        end else begin
            sat_model(longint'($signed(val[15:0])),
                      (op == 2) ? int'(fld[3:0]) + 1 : int'(fld[3:0]), op == 2, rl, ol);
            sat_model(longint'($signed(val[31:16])),
                      (op == 2) ? int'(fld[3:0]) + 1 : int'(fld[3:0]), op == 2, rh, oh);
            e.res = {rh[15:0], rl[15:0]};
            o = ol | oh;
        end
        e.unp = (dst == 4'd15) || (src == 4'd15);
        e.wr  = cond && !e.unp;
        e.ovf = e.wr && o;
        e.stk = model_stk;
        e.tag = tag;
        sb.push_back(e);
        if (clr)        model_stk = 1'b0;
        else if (e.ovf) model_stk = 1'b1;
    endtask

    always @(negedge clk) begin
        if (sb.size() > 0) begin
            exp_t e;
            bit bad;
            e = sb.pop_front();
            checks++;
            bad = (wr_en_o !== e.wr) || (ovf_o !== e.ovf) || (unpred_o !== e.unp) ||
                  (sticky_o !== e.stk) || (e.wr && (result_o !== e.res));
            if (bad) begin
                errors++;
                $display("FAIL %s: res=%h wr=%0d ovf=%0d unp=%0d stk=%0d expected res=%h wr=%0d ovf=%0d unp=%0d stk=%0d",
                         e.tag, result_o, wr_en_o, ovf_o, unpred_o, sticky_o,
                         e.res, e.wr, e.ovf, e.unp, e.stk);
            end
        end
    end

    task automatic summary();
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        #200000;
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog: run hung, expected completion");
            summary();
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        checks++;
        if (sticky_o !== 1'b0) begin
            errors++;
            $display("FAIL R8 reset: sticky=%0d expected 0", sticky_o);
        end
        rst_n = 1'b1;
        // R1 signed word, 8-bit and 32-bit widths
        drive("R1 pos clamp",  2'd0, 32'd1000,      5'd7,  5'd0, 0, 1, 4'd1, 4'd2, 0);
        drive("R1 neg clamp",  2'd0, -32'sd1000,    5'd7,  5'd0, 0, 1, 4'd1, 4'd2, 0);
        drive("R1 in range",   2'd0, 32'd50,        5'd7,  5'd0, 0, 1, 4'd1, 4'd2, 0);
        drive("R1 width 32",   2'd0, 32'h8000_0000, 5'd31, 5'd0, 0, 1, 4'd1, 4'd2, 0);
        drive("R1 width 1",    2'd0, 32'd1,         5'd0,  5'd0, 0, 1, 4'd1, 4'd2, 0);
        // R8 clear, R2 unsigned word
        drive("R8 clear",      2'd1, 32'd3,         5'd8,  5'd0, 0, 1, 4'd1, 4'd2, 1);
        drive("R2 high clamp", 2'd1, 32'd300,       5'd8,  5'd0, 0, 1, 4'd1, 4'd2, 0);
        drive("R2 neg to 0",   2'd1, -32'sd5,       5'd8,  5'd0, 0, 1, 4'd1, 4'd2, 0);
        drive("R2 width 0",    2'd1, 32'd7,         5'd0,  5'd0, 0, 1, 4'd1, 4'd2, 0);
        drive("R8 clr beats ovf", 2'd1, 32'd7,      5'd0,  5'd0, 0, 1, 4'd1, 4'd2, 1);
        drive("R2 zero width 0",  2'd1, 32'd0,      5'd0,  5'd0, 0, 1, 4'd1, 4'd2, 0);
        drive("R2 width 31 max",  2'd1, 32'h7FFF_FFFF, 5'd31, 5'd0, 0, 1, 4'd1, 4'd2, 0);
        // R3 pre-shift
        drive("R3 lsl",        2'd0, 32'd3,         5'd31, 5'd4, 0, 1, 4'd1, 4'd2, 0);
        drive("R3 lsl clamp",  2'd0, 32'h4000_0000, 5'd15, 5'd1, 0, 1, 4'd1, 4'd2, 0);
        drive("R3 asr by 32",  2'd0, 32'h8000_0000, 5'd31, 5'd0, 1, 1, 4'd1, 4'd2, 1);
        drive("R3 asr 8 uns",  2'd1, 32'h00F0_0000, 5'd16, 5'd8, 1, 1, 4'd1, 4'd2, 0);
        // R4 / R5 / R6 halves
        drive("R4 signed halves", 2'd2, 32'h7000_8123, 5'd7, 5'd0, 0, 1, 4'd1, 4'd2, 1);
        drive("R6 no sat halves", 2'd2, 32'h0003_FFFC, 5'd7, 5'd0, 0, 1, 4'd1, 4'd2, 0);
        drive("R6 high half only", 2'd3, 32'h8000_0004, 5'd8, 5'd0, 0, 1, 4'd1, 4'd2, 0);
        drive("R5 unsigned halves", 2'd3, 32'h8000_0012, 5'd4, 5'd0, 0, 1, 4'd1, 4'd2, 1);
        drive("R4 field bit4 ignored", 2'd3, 32'h0003_0004, 5'd24, 5'd0, 0, 1, 4'd1, 4'd2, 0);
        drive("R7 sticky holds",  2'd3, 32'h0003_0004, 5'd8, 5'd0, 0, 1, 4'd1, 4'd2, 0);
        // R9 condition fail
        drive("R9 cond low",      2'd0, 32'd1000,  5'd7,  5'd0, 0, 0, 4'd1, 4'd2, 0);
        drive("R9 sticky kept",   2'd0, 32'd1,     5'd7,  5'd0, 0, 1, 4'd1, 4'd2, 0);
        // R10 program-counter index
        drive("R10 dst pc",       2'd0, 32'd1000,  5'd7,  5'd0, 0, 1, 4'd15, 4'd2, 0);
        drive("R10 src pc nocond", 2'd1, 32'd1000, 5'd7,  5'd0, 0, 0, 4'd1, 4'd15, 0);
        drive("R10 sticky kept",  2'd0, 32'd1,     5'd7,  5'd0, 0, 1, 4'd1, 4'd2, 0);
        repeat (3) @(posedge clk);
        finished = 1'b1;
        summary();
    end
endmodule